// File: doc/BRIEF.md
# Reset Time-Out Sequencer

This block holds the chip's internal reset after a power-on pulse, a brown-out pulse or a wake from a power-managed mode. The reset stays held until a chain of up to three waits has run. The first wait is a power-up timer clocked by a slow RC tick. The second is an oscillator start-up counter clocked by the oscillator tick. The third is a PLL lock timer, also clocked by the slow tick. The waits always run in that order. Which of them run is decided at the trigger edge from three things: the oscillator mode code, an active-low power-up-timer enable bit, and the kind of event that started the sequence.

The external reset pin takes no part in the timing. The timers keep counting while the pin is low, and the pin only gates the final release. If the pin is held low until every wait is over, raising it releases the internal reset at the next clock edge.

Top module: `por_timeout_seq`

## Requirements
- R1: After `rst_ni` is asserted, `rst_int_o` is 1 and `seq_done_o` is 0. Both keep these values, whatever the ticks, until a power-on or brown-out sequence completes.
- R2: A cold trigger (`por_i` or `bor_i` high at a clock edge) with `pwrt_en_ni` = 0 first runs the power-up wait, which ends on the PWRT_TICKS-th sampled `slow_tick_i`. With `pwrt_en_ni` = 1 the power-up wait is skipped.
- R3: The oscillator wait runs for mode codes 0 (LP), 1 (XT), 2 (HS) and 3 (HS with PLL). It starts after the power-up wait or in its place, and ends on the OST_CYCLES-th sampled `osc_tick_i`. Codes 4 (EC), 5 (RC), 6 (INTIO) and 7 (reserved) skip it.
- R4: In mode code 3 only, a PLL wait of PLL_TICKS sampled `slow_tick_i` follows the oscillator wait.
- R5: `wake_i` is accepted only while `seq_done_o` is 1 and no cold trigger is present. It skips the power-up wait and runs only the oscillator and PLL waits that the mode calls for. For codes 4 to 7, `seq_done_o` stays 1.
- R6: A trigger for which no wait applies (for example code 5 with `pwrt_en_ni` = 1) sets `seq_done_o` at the edge that samples the trigger.
- R7: `seq_done_o` rises at the edge that counts the last tick of the last applicable wait. It then holds until the next accepted trigger.
- R8: At every edge, `rst_int_o` is registered as NOT(done-next AND `mclr_ni`). The pin held low keeps reset asserted while the timers run. Raising the pin after completion clears `rst_int_o` at the next edge.
- R9: A cold trigger in the middle of a sequence clears all counters and restarts from the first applicable wait. A `wake_i` in the middle of a sequence is ignored.
- R10: `mode_i` and `pwrt_en_ni` are sampled only at the trigger edge. Later changes do not alter the running sequence.
- R11: Ticks present in the trigger cycle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| slow_tick_i | input | 1 | Slow RC tick enable |
| osc_tick_i | input | 1 | Oscillator-input tick enable |
| por_i | input | 1 | Power-on pulse |
| bor_i | input | 1 | Brown-out pulse |
| wake_i | input | 1 | Wake from power-managed mode |
| mclr_ni | input | 1 | External reset pin, low holds reset |
| mode_i | input | 3 | Oscillator mode code |
| pwrt_en_ni | input | 1 | Power-up timer enable, active low |
| rst_int_o | output | 1 | Internal reset, active high |
| seq_done_o | output | 1 | All applicable waits finished |

## Verification
The hardest situation to reach from the ports is a restart or a configuration change that lands inside a particular wait. The bench gets there in two ways. Random runs fire cold pulses, wakes, mode flips and enable flips at random points while both tick streams toggle randomly. Directed cases start a sequence, count a known number of ticks, and then inject a brown-out or change `mode_i` partway through. A second hard case is the external pin held low across a complete sequence, which a directed case drives before releasing the pin.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned NUM_WAITS = 3;
  localparam int unsigned WAIT_PWRT = 0;
  localparam int unsigned WAIT_OST  = 1;
  localparam int unsigned WAIT_PLL  = 2;

  typedef enum logic [2:0] {
    OSC_LP    = 3'd0,
    OSC_XT    = 3'd1,
    OSC_HS    = 3'd2,
    OSC_HSPLL = 3'd3,
    OSC_EC    = 3'd4,
    OSC_RC    = 3'd5,
    OSC_INTIO = 3'd6
  } osc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRT,
    ST_OST,
    ST_PLL,
    ST_DONE
  } stage_e;
endpackage

// File: rtl/rst_seq_plan.sv
module rst_seq_plan
  import rst_seq_pkg::*;
(
  input  logic [2:0]           mode_i,
  input  logic                 pwrt_en_ni,
  input  logic                 cold_i,
  output logic [NUM_WAITS-1:0] mask_o
);
  logic crystal;

  always_comb begin
    crystal            = (mode_i <= 3'(OSC_HSPLL));
    mask_o             = '0;
    mask_o[WAIT_PWRT]  = cold_i & ~pwrt_en_ni;
    mask_o[WAIT_OST]   = crystal;
    mask_o[WAIT_PLL]   = (mode_i == 3'(OSC_HSPLL));
  end
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned   CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expire_o)  cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 2048,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned PLL_TICKS  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_tick_i,
  input  logic       osc_tick_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       wake_i,
  input  logic       mclr_ni,
  input  logic [2:0] mode_i,
  input  logic       pwrt_en_ni,
  output logic       rst_int_o,
  output logic       seq_done_o
);
  stage_e               stage_q, stage_d;
  logic [NUM_WAITS-1:0] pend_q, pend_d, plan_mask;
  logic [NUM_WAITS-1:0] run, tick, expire;
  logic                 cold, warm, trig, done_d;
  logic                 done_q, rst_int_q;

  assign cold = por_i | bor_i;
  assign warm = wake_i & ~cold & (stage_q == ST_DONE);
  assign trig = cold | warm;

  rst_seq_plan u_plan (
    .mode_i    (mode_i),
    .pwrt_en_ni(pwrt_en_ni),
    .cold_i    (cold),
    .mask_o    (plan_mask)
  );

  assign run[WAIT_PWRT]  = (stage_q == ST_PWRT);
  assign run[WAIT_OST]   = (stage_q == ST_OST);
  assign run[WAIT_PLL]   = (stage_q == ST_PLL);
  assign tick[WAIT_PWRT] = slow_tick_i;
  assign tick[WAIT_OST]  = osc_tick_i;
  assign tick[WAIT_PLL]  = slow_tick_i;

  for (genvar g = 0; g < NUM_WAITS; g++) begin : g_wait
    localparam int unsigned LIM = (g == WAIT_PWRT) ? PWRT_TICKS :
                                  (g == WAIT_OST)  ? OST_CYCLES : PLL_TICKS;
    rst_seq_timer #(.LIMIT(LIM)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (trig),
      .run_i   (run[g]),
      .tick_i  (tick[g]),
      .expire_o(expire[g])
    );
  end

  function automatic stage_e pick(input logic [NUM_WAITS-1:0] m);
    if (m[WAIT_PWRT]) return ST_PWRT;
    if (m[WAIT_OST])  return ST_OST;
    if (m[WAIT_PLL])  return ST_PLL;
    return ST_DONE;
  endfunction

  // clear lowest set bit: the stage just entered
  function automatic logic [NUM_WAITS-1:0] drop_first(input logic [NUM_WAITS-1:0] m);
    return m & (m - NUM_WAITS'(1));
  endfunction

  always_comb begin
    stage_d = stage_q;
    pend_d  = pend_q;
    if (trig) begin
      stage_d = pick(plan_mask);
      pend_d  = drop_first(plan_mask);
    end else if (|expire) begin
      stage_d = pick(pend_q);
      pend_d  = drop_first(pend_q);
    end
    done_d = (stage_d == ST_DONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_IDLE;
      pend_q    <= '0;
      done_q    <= 1'b0;
      rst_int_q <= 1'b1;
    end else begin
      stage_q   <= stage_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
      rst_int_q <= ~(done_d & mclr_ni);
    end
  end

  assign seq_done_o = done_q;
  assign rst_int_o  = rst_int_q;
endmodule

// File: rtl/por_timeout_seq_chk.sv
module por_timeout_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       bor_i,
  input logic       wake_i,
  input logic       mclr_ni,
  input logic [2:0] mode_i,
  input logic       pwrt_en_ni,
  input logic       rst_int_o,
  input logic       seq_done_o
);
  AST_RST_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_done_o |-> rst_int_o);  // R8

  AST_PIN_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclr_ni |=> rst_int_o);  // R8

  AST_PWRT_BLOCKS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i) && !pwrt_en_ni |=> !seq_done_o);  // R2

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o && !por_i && !bor_i && !wake_i |=> seq_done_o);  // R7

  AST_WAKE_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o && wake_i && !por_i && !bor_i && (mode_i > 3'd3) |=> seq_done_o);  // R5

  AST_WAKE_CRYSTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o && wake_i && !por_i && !bor_i && (mode_i <= 3'd3) |=> !seq_done_o);  // R5

  AST_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i) && pwrt_en_ni && (mode_i > 3'd3) |=> seq_done_o);  // R6
endmodule

bind por_timeout_seq por_timeout_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_i     (por_i),
  .bor_i     (bor_i),
  .wake_i    (wake_i),
  .mclr_ni   (mclr_ni),
  .mode_i    (mode_i),
  .pwrt_en_ni(pwrt_en_ni),
  .rst_int_o (rst_int_o),
  .seq_done_o(seq_done_o)
);

// File: tb/tb_por_timeout_seq.sv
`timescale 1ns/1ps
module tb_por_timeout_seq;
  localparam int unsigned P_PWRT = 16;
  localparam int unsigned P_OST  = 8;
  localparam int unsigned P_PLL  = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       slow = 1'b0, osc = 1'b0, por = 1'b0, bor = 1'b0, wake = 1'b0;
  logic       mclr_n = 1'b1, pwrt_en_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       rst_int, done;

  always #2.5 clk = ~clk;

  por_timeout_seq #(.PWRT_TICKS(P_PWRT), .OST_CYCLES(P_OST), .PLL_TICKS(P_PLL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .osc_tick_i(osc),
    .por_i(por), .bor_i(bor), .wake_i(wake), .mclr_ni(mclr_n),
    .mode_i(mode), .pwrt_en_ni(pwrt_en_n), .rst_int_o(rst_int), .seq_done_o(done)
  );

  int n_chk = 0, n_err = 0;
  int m_stage = -1;  // -1 idle, 0 pwrt, 1 ost, 2 pll, 3 done
  bit [2:0] m_mask = '0;
  int m_cnt = 0;

  function automatic bit [2:0] exp_mask(logic [2:0] md, logic en_n, bit cold);
    bit [2:0] r;
    r[0] = cold && !en_n;
    r[1] = (md <= 3'd3);
    r[2] = (md == 3'd3);
    return r;
  endfunction

  function automatic int next_stage(bit [2:0] mask, int after);
    for (int s = after + 1; s < 3; s++) if (mask[s]) return s;
    return 3;
  endfunction

  function automatic int stage_len(int s);
    return (s == 0) ? P_PWRT : (s == 1) ? P_OST : P_PLL;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; drives, lets one posedge pass, updates the model, checks at next negedge
  task automatic cyc(bit s, bit o, bit p, bit b, bit w, bit m_n);
    bit cold, warm, t, exp_done;
    slow = s; osc = o; por = p; bor = b; wake = w; mclr_n = m_n;
    @(posedge clk);
    cold = p || b;
    warm = w && !cold && (m_stage == 3);
    if (cold || warm) begin
      m_mask  = exp_mask(mode, pwrt_en_n, cold);
      m_stage = next_stage(m_mask, -1);
      m_cnt   = 0;
    end else if (m_stage >= 0 && m_stage < 3) begin
      t = (m_stage == 1) ? o : s;
      if (t) begin
        m_cnt++;
        if (m_cnt == stage_len(m_stage)) begin
          m_stage = next_stage(m_mask, m_stage);
          m_cnt   = 0;
        end
      end
    end
    @(negedge clk);
    exp_done = (m_stage == 3);
    check(done === exp_done, "R7 seq_done_o", int'(done), int'(exp_done));
    check(rst_int === !(exp_done && m_n), "R8 rst_int_o", int'(rst_int), int'(!(exp_done && m_n)));
  endtask

  task automatic run_count(output int n);
    n = 0;
    while (!done && n < 1000) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    check(rst_int === 1'b1 && done === 1'b0, "R1 reset state", int'({rst_int, done}), 2);
    rst_n = 1'b1;
    repeat (20) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check(done === 1'b0, "R1 no trigger keeps reset", int'(done), 0);

    // R6: RC with timer disabled, no wait at all
    mode = 3'd5; pwrt_en_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check(done === 1'b1 && rst_int === 1'b0, "R6 zero-wait release", int'({done, rst_int}), 2);

    // R2 + R11: EC with timer enabled, ticks in trigger cycle ignored
    mode = 3'd4; pwrt_en_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    run_count(n);
    check(n == P_PWRT, "R2 R11 power-up wait length", n, P_PWRT);

    // R3: HS with timer disabled
    mode = 3'd2; pwrt_en_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    run_count(n);
    check(n == P_OST, "R3 oscillator wait length", n, P_OST);

    // R4: HSPLL full chain
    mode = 3'd3; pwrt_en_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    run_count(n);
    check(n == P_PWRT + P_OST + P_PLL, "R4 full chain length", n, P_PWRT + P_OST + P_PLL);

    // R5: wake in HSPLL skips power-up wait
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_count(n);
    check(n == P_OST + P_PLL, "R5 wake crystal wait", n, P_OST + P_PLL);
    mode = 3'd4;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check(done === 1'b1 && rst_int === 1'b0, "R5 wake EC no wait", int'({done, rst_int}), 2);

    // R9: brown-out mid-sequence restarts, wake mid-sequence ignored
    mode = 3'd4; pwrt_en_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (10) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_count(n);
    check(n + 1 == P_PWRT, "R9 restart and ignored wake", n + 1, P_PWRT);

    // R10: configuration change after trigger has no effect
    mode = 3'd2; pwrt_en_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    mode = 3'd5; pwrt_en_n = 1'b1;
    run_count(n);
    check(n == P_PWRT + P_OST, "R10 sampled configuration", n, P_PWRT + P_OST);

    // R8: pin low across whole sequence, release afterwards
    mode = 3'd2; pwrt_en_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (P_PWRT + P_OST + 4) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check(done === 1'b1 && rst_int === 1'b1, "R8 pin holds reset", int'({done, rst_int}), 3);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check(rst_int === 1'b0, "R8 release on pin high", int'(rst_int), 0);

    // random phase
    for (int t = 0; t < 150; t++) begin
      int ev, len;
      mode      = 3'($urandom_range(0, 7));
      pwrt_en_n = 1'($urandom_range(0, 1));
      ev        = $urandom_range(0, 2);
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ev == 0, ev == 1, ev == 2, 1'b1);
      len = $urandom_range(20, 90);
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(0, 15) == 0) begin
          mode      = 3'($urandom_range(0, 7));
          pwrt_en_n = 1'($urandom_range(0, 1));
        end
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            $urandom_range(0, 80) == 0, $urandom_range(0, 80) == 0,
            $urandom_range(0, 30) == 0, $urandom_range(0, 9) != 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule